// File: doc/BRIEF.md
# Ethernet MAC Control and Statistics Register Bank

This block is the software-visible control store of an Ethernet MAC. A simple word-addressed bus reads and writes 32-bit registers. The registers hold the operating mode, the station address, the multicast hash, two VLAN tags, wakeup control, system control and status, receive and transmit status, sticky and interrupt-enable words, and counter control with its interrupt words. Two banks of statistics counters, one for receive and one for transmit, sit in the same space.

Each register follows its own access rule. Some are plain read/write. Some clear only selected bits when ones are written to them. Status words ignore writes. The counter-control word has a self-clearing action bit. The frame datapath sets status bits and bumps counters through one-cycle pulse inputs. The MAC reads the control values from dedicated output ports.

A bus access takes one cycle. Read data and any error indication appear in the following cycle.

Top module: `macreg_top`

## Requirements
- R1: After reset, word 1 reads 0xFFFFFFFF, word 2 reads 0x0000FFFF, words 5 and 6 read 0x0000FFFF, word 8 reads 0x00003F00, word 16 reads 0x0000000A, and every other register and counter reads zero.
- R2: The following words are plain read/write, and a read returns the last value written: 0 mode, 1 address low, 2 address high, 3 and 4 hash, 5 and 6 VLAN, 8 system control, and the enables at 12, 15, 18 and 20. A read sets bus_rvalid with its data in the cycle after the access. sta_addr_o is {word2[15:0], word1}.
- R3: System status (word 9) clears a bit only when a one is written to it and the bit lies in mask 0xE1. Its other bits ignore writes. sys_evt_set pulses set bits.
- R4: In wakeup control (word 7), writing a one clears any bit inside mask 0xF20. Bits outside the mask take the written value. wake_evt_set sets bits, but only inside the mask.
- R5: The receive sticky (11), transmit sticky (14), receive-counter interrupt status (17) and transmit-counter interrupt status (19) words clear a bit on any written one, across all 32 bits. They are set by rx_evt_set, tx_evt_set, cnt_rx_irq_set and cnt_tx_irq_set. A set in the same cycle as a clear wins.
- R6: Writes to receive status (10) and transmit status (13) have no effect. These words change only through rx_evt_set and tx_evt_set and through the enable-edge rule.
- R7: Writing word 16 with bit 0 set zeroes every statistics counter. Bit 0 always reads zero, and the other bits keep the written value.
- R8: A write to word 0 that takes bit 0 (receive enable) from 0 to 1 clears bit 31 of word 10. A write that takes bit 1 (transmit enable) from 0 to 1 clears bit 31 of word 13. A write that leaves an enable at 1 clears nothing.
- R9: Receive counter k sits at word 32+k, and transmit counter k at word 64+k. A counter increments on a one-cycle pulse on its inc bit and loads a written value. A counter clear in the same cycle as an increment wins.
- R10: An access to an unmapped word raises bus_err for exactly one cycle after the access. The unmapped words are 21 to 23, receive-counter words at or above 32+N_RX, transmit-counter words at or above 64+N_TX, and everything else not named here. A read of such a word also returns zero with bus_rvalid.
- R11: Words 24 to 31 are a reserved range. Accesses to it raise no error, reads return zero, and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Invalid-access pulse |
| sys_evt_set | input | 32 | System status set pulses |
| wake_evt_set | input | 32 | Wakeup control set pulses |
| rx_evt_set | input | 32 | Receive status and sticky set pulses |
| tx_evt_set | input | 32 | Transmit status and sticky set pulses |
| cnt_rx_irq_set | input | 32 | Receive counter interrupt set pulses |
| cnt_tx_irq_set | input | 32 | Transmit counter interrupt set pulses |
| rx_cnt_inc | input | N_RX | Receive counter increment pulses |
| tx_cnt_inc | input | N_TX | Transmit counter increment pulses |
| mode_o | output | 32 | Operating mode word |
| sta_addr_o | output | 48 | Station address |
| hash_o | output | 64 | Hash filter {word4, word3} |
| vlan_a_o | output | 32 | First VLAN tag word |
| vlan_b_o | output | 32 | Second VLAN tag word |
| sys_ctl_o | output | 32 | System control word |
| wake_ctl_o | output | 32 | Wakeup control word |
| rx_irq_en_o | output | 32 | Receive interrupt enables |
| tx_irq_en_o | output | 32 | Transmit interrupt enables |
| cnt_rx_irq_en_o | output | 32 | Receive counter interrupt enables |
| cnt_tx_irq_en_o | output | 32 | Transmit counter interrupt enables |

## Verification
The assertions assume that bus_addr and bus_wr are steady whenever bus_en is high. They also assume that status is never cleared through a mode write in the same cycle that the datapath sets the same bit. The stimulus drives every bus access and every datapath pulse for exactly one cycle, between clock edges, and spaces accesses apart with an idle cycle. It raises a set pulse together with a write only where the same-cycle priority rule is the thing under test, and never during a mode write.

// File: rtl/macreg_pkg.sv
package macreg_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 21;
  localparam int IGN_LO   = 24;
  localparam int IGN_HI   = 31;
  localparam int RXC_BASE = 32;
  localparam int TXC_BASE = 64;

  localparam int R_MODE = 0,  R_ADLO = 1,  R_ADHI = 2,  R_HSLO = 3,  R_HSHI = 4;
  localparam int R_VLA  = 5,  R_VLB  = 6,  R_WAKE = 7,  R_SCTL = 8,  R_SSTA = 9;
  localparam int R_RXST = 10, R_RXSK = 11, R_RXIE = 12, R_TXST = 13, R_TXSK = 14;
  localparam int R_TXIE = 15, R_CCTL = 16, R_CRXS = 17, R_CRXE = 18, R_CTXS = 19;
  localparam int R_CTXE = 20;

  localparam int MODE_RX_EN = 0;
  localparam int MODE_TX_EN = 1;
  localparam int DONE_BIT   = 31;
  localparam int CLR_BIT    = 0;

  localparam logic [DATA_W-1:0] WAKE_W1C = 32'h0000_0F20;
  localparam logic [DATA_W-1:0] SSTA_W1C = 32'h0000_00E1;

  typedef enum logic [2:0] {K_REG, K_IGN, K_RXC, K_TXC, K_BAD} acc_kind_t;

  function automatic logic [DATA_W-1:0] reset_of(input int i);
    case (i)
      R_ADLO:              return 32'hFFFF_FFFF;
      R_ADHI, R_VLA, R_VLB: return 32'h0000_FFFF;
      R_SCTL:              return 32'h0000_3F00;
      R_CCTL:              return 32'h0000_000A;
      default:             return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] plain_of(input int i);
    case (i)
      R_WAKE:                                    return ~WAKE_W1C;
      R_CCTL:                                    return ~(32'h1 << CLR_BIT);
      R_SSTA, R_RXST, R_RXSK, R_TXST, R_TXSK,
      R_CRXS, R_CTXS:                            return '0;
      default:                                   return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] w1c_of(input int i);
    case (i)
      R_WAKE:                         return WAKE_W1C;
      R_SSTA:                         return SSTA_W1C;
      R_RXSK, R_TXSK, R_CRXS, R_CTXS: return '1;
      default:                        return '0;
    endcase
  endfunction

  // Next value of one register word: write, then write-one-clear, then
  // event clear; datapath sets take priority over all of them.
  function automatic logic [DATA_W-1:0] field_next(
      input logic [DATA_W-1:0] q, input logic wr, input logic [DATA_W-1:0] wd,
      input logic [DATA_W-1:0] plain, input logic [DATA_W-1:0] w1c,
      input logic [DATA_W-1:0] clr, input logic [DATA_W-1:0] set);
    logic [DATA_W-1:0] n;
    n = wr ? ((q & ~plain) | (wd & plain)) : q;
    n = n & ~(wr ? (wd & w1c) : '0);
    n = n & ~clr;
    return n | set;
  endfunction
endpackage

// File: rtl/macreg_decode.sv
module macreg_decode import macreg_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int N_RX   = 8,
  parameter int N_TX   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [ADDR_W-1:0] idx
);
  int unsigned a;
  always_comb begin
    a    = 32'(addr);
    kind = K_BAD;
    idx  = '0;
    if (a < NUM_REGS) begin
      kind = K_REG;
      idx  = addr;
    end else if (a >= IGN_LO && a <= IGN_HI) begin
      kind = K_IGN;
    end else if (a >= RXC_BASE && a < RXC_BASE + N_RX) begin
      kind = K_RXC;
      idx  = ADDR_W'(a - RXC_BASE);
    end else if (a >= TXC_BASE && a < TXC_BASE + N_TX) begin
      kind = K_TXC;
      idx  = ADDR_W'(a - TXC_BASE);
    end
  end
endmodule

// File: rtl/macreg_field.sv
module macreg_field import macreg_pkg::*; #(
  parameter logic [DATA_W-1:0] RST   = '0,
  parameter logic [DATA_W-1:0] PLAIN = '0,
  parameter logic [DATA_W-1:0] W1C   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else        q <= field_next(q, wr, wdata, PLAIN, W1C, clr, set);
  end
endmodule

// File: rtl/macreg_cnt_bank.sv
module macreg_cnt_bank #(
  parameter int N      = 8,
  parameter int W      = 32,
  parameter int DW     = 32,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [N-1:0]     inc,
  output logic [W-1:0]     cnt [N]
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt[g] <= '0;
        else if (clr)                                cnt[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))       cnt[g] <= wr_data[W-1:0];
        else if (inc[g])                             cnt[g] <= cnt[g] + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/macreg_top.sv
module macreg_top import macreg_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int N_RX   = 8,
  parameter int N_TX   = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [31:0]       sys_evt_set,
  input  logic [31:0]       wake_evt_set,
  input  logic [31:0]       rx_evt_set,
  input  logic [31:0]       tx_evt_set,
  input  logic [31:0]       cnt_rx_irq_set,
  input  logic [31:0]       cnt_tx_irq_set,
  input  logic [N_RX-1:0]   rx_cnt_inc,
  input  logic [N_TX-1:0]   tx_cnt_inc,
  output logic [31:0]       mode_o,
  output logic [47:0]       sta_addr_o,
  output logic [63:0]       hash_o,
  output logic [31:0]       vlan_a_o,
  output logic [31:0]       vlan_b_o,
  output logic [31:0]       sys_ctl_o,
  output logic [31:0]       wake_ctl_o,
  output logic [31:0]       rx_irq_en_o,
  output logic [31:0]       tx_irq_en_o,
  output logic [31:0]       cnt_rx_irq_en_o,
  output logic [31:0]       cnt_tx_irq_en_o
);
  localparam int RX_IDX_W  = (N_RX > 1) ? $clog2(N_RX) : 1;
  localparam int TX_IDX_W  = (N_TX > 1) ? $clog2(N_TX) : 1;
  localparam int REG_IDX_W = $clog2(NUM_REGS);

  acc_kind_t          acc_kind;
  logic [ADDR_W-1:0]  acc_idx;
  logic               wr_hit, rd_hit;
  logic [NUM_REGS-1:0] reg_wr;
  logic [DATA_W-1:0]  regq    [NUM_REGS];
  logic [DATA_W-1:0]  set_vec [NUM_REGS];
  logic [DATA_W-1:0]  clr_vec [NUM_REGS];
  logic               rx_rise, tx_rise, cnt_clr, cnt_nonzero;
  logic [DATA_W-1:0]  rx_stat_q;
  logic [CNT_W-1:0]   rx_cnt [N_RX];
  logic [CNT_W-1:0]   tx_cnt [N_TX];
  logic [DATA_W-1:0]  rd_word;

  macreg_decode #(.ADDR_W(ADDR_W), .N_RX(N_RX), .N_TX(N_TX)) u_dec (
    .addr(bus_addr), .kind(acc_kind), .idx(acc_idx)
  );

  assign wr_hit = bus_en && bus_wr;
  assign rd_hit = bus_en && !bus_wr;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      reg_wr[i] = wr_hit && (acc_kind == K_REG) && (acc_idx == ADDR_W'(i));
  end

  // Events derived from the bus write, named for the checker.
  assign rx_rise = reg_wr[R_MODE] && !regq[R_MODE][MODE_RX_EN] && bus_wdata[MODE_RX_EN];
  assign tx_rise = reg_wr[R_MODE] && !regq[R_MODE][MODE_TX_EN] && bus_wdata[MODE_TX_EN];
  assign cnt_clr = reg_wr[R_CCTL] && bus_wdata[CLR_BIT];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      set_vec[i] = '0;
      clr_vec[i] = '0;
    end
    set_vec[R_WAKE] = wake_evt_set & WAKE_W1C;
    set_vec[R_SSTA] = sys_evt_set;
    set_vec[R_RXST] = rx_evt_set;
    set_vec[R_RXSK] = rx_evt_set;
    set_vec[R_TXST] = tx_evt_set;
    set_vec[R_TXSK] = tx_evt_set;
    set_vec[R_CRXS] = cnt_rx_irq_set;
    set_vec[R_CTXS] = cnt_tx_irq_set;
    clr_vec[R_RXST] = DATA_W'(rx_rise) << DONE_BIT;
    clr_vec[R_TXST] = DATA_W'(tx_rise) << DONE_BIT;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      macreg_field #(
        .RST(reset_of(gi)), .PLAIN(plain_of(gi)), .W1C(w1c_of(gi))
      ) u_fld (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr[gi]), .wdata(bus_wdata),
        .set(set_vec[gi]), .clr(clr_vec[gi]), .q(regq[gi])
      );
    end
  endgenerate

  macreg_cnt_bank #(.N(N_RX), .W(CNT_W), .DW(DATA_W)) u_rxc (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .wr_en(wr_hit && acc_kind == K_RXC), .wr_idx(acc_idx[RX_IDX_W-1:0]),
    .wr_data(bus_wdata), .inc(rx_cnt_inc), .cnt(rx_cnt)
  );

  macreg_cnt_bank #(.N(N_TX), .W(CNT_W), .DW(DATA_W)) u_txc (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .wr_en(wr_hit && acc_kind == K_TXC), .wr_idx(acc_idx[TX_IDX_W-1:0]),
    .wr_data(bus_wdata), .inc(tx_cnt_inc), .cnt(tx_cnt)
  );

  always_comb begin
    cnt_nonzero = 1'b0;
    for (int i = 0; i < N_RX; i++) cnt_nonzero = cnt_nonzero || (rx_cnt[i] != '0);
    for (int i = 0; i < N_TX; i++) cnt_nonzero = cnt_nonzero || (tx_cnt[i] != '0);
  end

  always_comb begin
    case (acc_kind)
      K_REG:   rd_word = regq[acc_idx[REG_IDX_W-1:0]];
      K_RXC:   rd_word = DATA_W'(rx_cnt[acc_idx[RX_IDX_W-1:0]]);
      K_TXC:   rd_word = DATA_W'(tx_cnt[acc_idx[TX_IDX_W-1:0]]);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      bus_err    <= bus_en && (acc_kind == K_BAD);
      bus_rdata  <= rd_hit ? rd_word : '0;
    end
  end

  assign rx_stat_q       = regq[R_RXST];
  assign mode_o          = regq[R_MODE];
  assign sta_addr_o      = {regq[R_ADHI][15:0], regq[R_ADLO]};
  assign hash_o          = {regq[R_HSHI], regq[R_HSLO]};
  assign vlan_a_o        = regq[R_VLA];
  assign vlan_b_o        = regq[R_VLB];
  assign sys_ctl_o       = regq[R_SCTL];
  assign wake_ctl_o      = regq[R_WAKE];
  assign rx_irq_en_o     = regq[R_RXIE];
  assign tx_irq_en_o     = regq[R_TXIE];
  assign cnt_rx_irq_en_o = regq[R_CRXE];
  assign cnt_tx_irq_en_o = regq[R_CTXE];
endmodule

// File: rtl/macreg_chk.sv
module macreg_chk import macreg_pkg::*; #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input acc_kind_t         acc_kind,
  input logic [ADDR_W-1:0] acc_idx,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic [31:0]       bus_rdata,
  input logic              cnt_clr,
  input logic              cnt_nonzero,
  input logic              rx_rise,
  input logic [31:0]       rx_evt_set,
  input logic [31:0]       rx_stat_q
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr) |=> bus_rvalid);

  assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && acc_kind == K_REG && acc_idx == ADDR_W'(R_RXST) && rx_evt_set == '0)
    |=> $stable(rx_stat_q));

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_nonzero);

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rise && !rx_evt_set[DONE_BIT]) |=> !rx_stat_q[DONE_BIT]);

  assert_err_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && acc_kind == K_BAD) |=> bus_err);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_en && acc_kind == K_BAD));

  assert_ign_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(acc_kind == K_IGN)) |-> (bus_rdata == '0 && !bus_err));
endmodule

bind macreg_top macreg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .acc_kind(acc_kind), .acc_idx(acc_idx), .bus_rvalid(bus_rvalid),
  .bus_err(bus_err), .bus_rdata(bus_rdata), .cnt_clr(cnt_clr),
  .cnt_nonzero(cnt_nonzero), .rx_rise(rx_rise), .rx_evt_set(rx_evt_set),
  .rx_stat_q(rx_stat_q)
);

// File: tb/macreg_top_tb.sv
module macreg_top_tb;
  localparam int AW = 7;
  localparam int NR = 8;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err;
  logic [31:0] sys_evt_set = '0, wake_evt_set = '0, rx_evt_set = '0, tx_evt_set = '0;
  logic [31:0] cnt_rx_irq_set = '0, cnt_tx_irq_set = '0;
  logic [NR-1:0] rx_cnt_inc = '0;
  logic [NT-1:0] tx_cnt_inc = '0;
  logic [31:0] mode_o, vlan_a_o, vlan_b_o, sys_ctl_o, wake_ctl_o;
  logic [31:0] rx_irq_en_o, tx_irq_en_o, cnt_rx_irq_en_o, cnt_tx_irq_en_o;
  logic [47:0] sta_addr_o;
  logic [63:0] hash_o;

  always #5 clk = ~clk;

  macreg_top #(.ADDR_W(AW), .N_RX(NR), .N_TX(NT), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .sys_evt_set(sys_evt_set), .wake_evt_set(wake_evt_set),
    .rx_evt_set(rx_evt_set), .tx_evt_set(tx_evt_set), .cnt_rx_irq_set(cnt_rx_irq_set),
    .cnt_tx_irq_set(cnt_tx_irq_set), .rx_cnt_inc(rx_cnt_inc), .tx_cnt_inc(tx_cnt_inc),
    .mode_o(mode_o), .sta_addr_o(sta_addr_o), .hash_o(hash_o), .vlan_a_o(vlan_a_o),
    .vlan_b_o(vlan_b_o), .sys_ctl_o(sys_ctl_o), .wake_ctl_o(wake_ctl_o),
    .rx_irq_en_o(rx_irq_en_o), .tx_irq_en_o(tx_irq_en_o),
    .cnt_rx_irq_en_o(cnt_rx_irq_en_o), .cnt_tx_irq_en_o(cnt_tx_irq_en_o)
  );

  typedef struct {
    logic [31:0] data;
    bit          rv;
    bit          err;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0;
  int n_errs = 0;
  bit finished = 1'b0;

  // Pulses staged for the next bus cycle.
  logic [31:0] p_sys = '0, p_wake = '0, p_rx = '0, p_tx = '0, p_crx = '0;
  logic [NR-1:0] p_rxinc = '0;
  logic [NT-1:0] p_txinc = '0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = en; bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
    sys_evt_set = p_sys; wake_evt_set = p_wake; rx_evt_set = p_rx; tx_evt_set = p_tx;
    cnt_rx_irq_set = p_crx; rx_cnt_inc = p_rxinc; tx_cnt_inc = p_txinc;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    sys_evt_set = '0; wake_evt_set = '0; rx_evt_set = '0; tx_evt_set = '0;
    cnt_rx_irq_set = '0; rx_cnt_inc = '0; tx_cnt_inc = '0;
    p_sys = '0; p_wake = '0; p_rx = '0; p_tx = '0; p_crx = '0; p_rxinc = '0; p_txinc = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input bit e, input string tag);
    exp_t it;
    it.data = exp; it.rv = 1'b1; it.err = e; it.tag = tag;
    sb.push_back(it);
    cyc(1'b1, 1'b0, a, '0);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit e, input string tag);
    exp_t it;
    if (e) begin
      it.data = '0; it.rv = 1'b0; it.err = 1'b1; it.tag = tag;
      sb.push_back(it);
    end
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic pulse();
    cyc(1'b0, 1'b0, 0, '0);
  endtask

  // Monitor: every response is matched against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (bus_rvalid || bus_err)) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_errs++;
        $display("FAIL unexpected response: actual rv=%0b err=%0b data=%h expected none",
                 bus_rvalid, bus_err, bus_rdata);
      end else begin
        exp_t it;
        it = sb.pop_front();
        if (bus_rvalid !== it.rv || bus_err !== it.err || (it.rv && bus_rdata !== it.data)) begin
          n_errs++;
          $display("FAIL %s: actual rv=%0b err=%0b data=%h expected rv=%0b err=%0b data=%h",
                   it.tag, bus_rvalid, bus_err, bus_rdata, it.rv, it.err, it.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({62'd0, bus_rvalid, bus_err}, 64'd0, "R1 idle outputs");
    check(64'(sta_addr_o), 64'h0000_FFFF_FFFF_FFFF, "R1 station address");
    check(64'(vlan_a_o), 64'h0000_FFFF, "R1 vlan a port");
    check(64'(sys_ctl_o), 64'h3F00, "R1 sysctl port");
    rd(0, 32'h0, 1'b0, "R1 mode");
    rd(1, 32'hFFFF_FFFF, 1'b0, "R1 addr lo");
    rd(2, 32'h0000_FFFF, 1'b0, "R1 addr hi");
    rd(5, 32'h0000_FFFF, 1'b0, "R1 vlan a");
    rd(6, 32'h0000_FFFF, 1'b0, "R1 vlan b");
    rd(8, 32'h0000_3F00, 1'b0, "R1 sysctl");
    rd(16, 32'h0000_000A, 1'b0, "R1 cnt ctl");
    rd(10, 32'h0, 1'b0, "R1 rx status");
    rd(33, 32'h0, 1'b0, "R1 rx counter");

    // R2 plain registers
    wr(3, 32'h1234_5678, 1'b0, "R2");
    rd(3, 32'h1234_5678, 1'b0, "R2 hash lo");
    wr(1, 32'hA1B2_C3D4, 1'b0, "R2");
    wr(2, 32'h0000_5566, 1'b0, "R2");
    check(64'(sta_addr_o), 64'h0000_5566_A1B2_C3D4, "R2 station address port");
    wr(8, 32'h0000_1234, 1'b0, "R2");
    rd(8, 32'h0000_1234, 1'b0, "R2 sysctl");
    wr(12, 32'h0000_000F, 1'b0, "R2");
    check(64'(rx_irq_en_o), 64'hF, "R2 rx irq enable port");

    // R3 system status
    p_sys = 32'hFF; pulse();
    rd(9, 32'hFF, 1'b0, "R3 set");
    wr(9, 32'hFF, 1'b0, "R3");
    rd(9, 32'h1E, 1'b0, "R3 masked clear");

    // R4 wakeup control
    wr(7, 32'h0000_0FFF, 1'b0, "R4");
    rd(7, 32'h0000_00DF, 1'b0, "R4 plain bits");
    p_wake = 32'hFFFF_FFFF; pulse();
    rd(7, 32'h0000_0FFF, 1'b0, "R4 masked set");
    wr(7, 32'h0000_0120, 1'b0, "R4");
    rd(7, 32'h0000_0E00, 1'b0, "R4 clear plus load");
    check(64'(wake_ctl_o), 64'hE00, "R4 port");

    // R5 sticky and counter interrupt status
    p_rx = 32'h8000_0005; pulse();
    rd(11, 32'h8000_0005, 1'b0, "R5 sticky set");
    wr(11, 32'h1, 1'b0, "R5");
    rd(11, 32'h8000_0004, 1'b0, "R5 sticky clear");
    p_rx = 32'h4; wr(11, 32'h4, 1'b0, "R5");
    rd(11, 32'h8000_0004, 1'b0, "R5 set beats clear");
    p_crx = 32'hF0; pulse();
    wr(17, 32'h30, 1'b0, "R5");
    rd(17, 32'hC0, 1'b0, "R5 counter irq status");

    // R6 status writes ignored
    wr(10, 32'h0, 1'b0, "R6");
    rd(10, 32'h8000_0005, 1'b0, "R6 rx status kept");

    // R8 enable rising edge
    wr(0, 32'h1, 1'b0, "R8");
    rd(10, 32'h0000_0005, 1'b0, "R8 rx done cleared");
    p_rx = 32'h8000_0000; pulse();
    wr(0, 32'h1, 1'b0, "R8");
    rd(10, 32'h8000_0005, 1'b0, "R8 no edge no clear");
    p_tx = 32'h8000_0000; pulse();
    wr(0, 32'h3, 1'b0, "R8");
    rd(13, 32'h0, 1'b0, "R8 tx done cleared");
    rd(10, 32'h8000_0005, 1'b0, "R8 rx kept");
    rd(14, 32'h8000_0000, 1'b0, "R5 tx sticky kept");
    check(64'(mode_o), 64'h3, "R2 mode port");

    // R9 counters
    for (int i = 0; i < 3; i++) begin p_rxinc = 8'h01; pulse(); end
    p_rxinc = 8'h04; pulse();
    for (int i = 0; i < 2; i++) begin p_txinc = 8'h02; pulse(); end
    rd(32, 32'd3, 1'b0, "R9 rx0");
    rd(34, 32'd1, 1'b0, "R9 rx2");
    rd(65, 32'd2, 1'b0, "R9 tx1");
    rd(33, 32'd0, 1'b0, "R9 rx1 untouched");
    wr(33, 32'd100, 1'b0, "R9");
    rd(33, 32'd100, 1'b0, "R9 load");

    // R7 counter clear, with a competing increment (R9)
    p_rxinc = 8'h01; wr(16, 32'h5, 1'b0, "R7");
    rd(32, 32'd0, 1'b0, "R9 clear beats inc");
    rd(33, 32'd0, 1'b0, "R7 rx cleared");
    rd(65, 32'd0, 1'b0, "R7 tx cleared");
    rd(16, 32'h4, 1'b0, "R7 bit0 reads zero");

    // R10 unmapped
    rd(22, 32'h0, 1'b1, "R10 gap read");
    wr(100, 32'hDEAD_BEEF, 1'b1, "R10 high write");
    rd(40, 32'h0, 1'b1, "R10 past rx bank");
    rd(72, 32'h0, 1'b1, "R10 past tx bank");
    rd(71, 32'h0, 1'b0, "R10 last tx ok");

    // R11 reserved range
    wr(26, 32'h55, 1'b0, "R11");
    rd(26, 32'h0, 1'b0, "R11 read zero");
    rd(31, 32'h0, 1'b0, "R11 top of range");

    repeat (4) @(negedge clk);
    check(64'(sb.size()), 64'd0, "R2 all responses seen");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule